// File: doc/BRIEF.md
# Frequency Fall-Back Watchdog

This block guards a change of the clock-generator frequency selection made by software. Software first chooses a 5-bit frequency code and a source bit that says whether the code comes from the bus register or from the strap pins. It then arms the watchdog with an interval in whole seconds. A 1 Hz tick pulse counts the interval down. If the system does not come back and service the watchdog before the interval runs out, the block enters a recovery sequence. It clears the enable, forces the active selection to a fall-back code, and drives an active-low reset pulse so the system restarts at that code.

The recovery stage is watched with the same interval. If the restarted system services the watchdog, the fall-back code becomes the permanent bus selection. If the restarted system also stays silent, a second reset pulse is issued and the selection falls back to the strap-latched code. While recovery is running, software writes to the enable and to the selection are held off.

Top module: `freq_fallback_wdog`

## Requirements
- R1: After reset the enable reads 0, the reset output is high, the bus source bit and the bus code read 0, and the frequency output equals the strap code.
- R2: A write that sets the enable while it is 0 arms the watchdog with the interval input N. The first expiry happens on the Nth tick that follows, and on the first tick when N is 0.
- R3: A service strobe during the first stage reloads the interval, so N further ticks are needed before expiry.
- R4: On the first expiry the enable reads 0 and the frequency output switches to the fall-back code input.
- R5: Every expiry drives the reset output low from the next clock for exactly 16 clock cycles.
- R6: If the recovery stage expires, the bus source bit becomes 0 and the frequency output returns to the strap code.
- R7: A service strobe during recovery copies the fall-back code into the bus code, sets the bus source bit to 1 and ends recovery.
- R8: During recovery, enable writes and selection writes have no effect.
- R9: While the watchdog is idle (never armed, or disarmed by writing the enable to 0), ticks and service strobes change nothing.
- R10: Outside recovery, the frequency output is the bus code when the bus source bit is 1 and the strap code when it is 0. A change on the strap input shows through without delay only in the strap case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | Enable value written by cfg_wr |
| cfg_interval | input | 6 | Watchdog interval in seconds |
| sel_wr | input | 1 | Write strobe for the bus selection |
| sel_src | input | 1 | Source bit written: 1 bus code, 0 strap code |
| sel_code | input | 5 | Bus frequency code written |
| fb_code | input | 5 | Fall-back frequency code |
| strap_code | input | 5 | Strap-latched frequency code |
| service | input | 1 | Watchdog service strobe |
| wd_rst_n | output | 1 | Active-low system reset pulse |
| freq_code | output | 5 | Active frequency selection |
| wd_en | output | 1 | Enable bit readback |
| bus_src | output | 1 | Bus source bit readback |
| bus_code | output | 5 | Bus frequency code readback |

## Verification
Every registered result (enable, bus readbacks, stage-driven frequency code and the start of the reset pulse) is due on the clock edge that captures the strobe or tick. A strap change in the strap-source case is visible in the same cycle. The driver applies each stimulus just after a rising edge and queues its expectation for the cycle in which that edge takes effect. The monitor compares the expectation at the following falling edge. The reset pulse is checked in each of its 16 low cycles and on the cycle it returns high.

// File: rtl/wdfb_pkg.sv
// Shared types for the frequency fall-back watchdog.
// Assumes nothing beyond standard SystemVerilog packages.
package wdfb_pkg;
    typedef enum logic [1:0] {
        WD_IDLE     = 2'd0,
        WD_TARGET   = 2'd1,
        WD_FALLBACK = 2'd2
    } wd_stage_e;
endpackage

// File: rtl/wd_tick_counter.sv
// Seconds down-counter: loads an interval and counts ticks while running.
// It flags expiry on the tick that finds the count at 1 or below.
// Assumes tick is a single-cycle pulse. A load wins over a tick in the same cycle.
module wd_tick_counter #(
    parameter int IVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IVL_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    logic [IVL_W-1:0] cnt;

    // Count register: reload, or decrement on a tick while above one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && tick && cnt > 1)
            cnt <= cnt - 1'b1;
    end

    // Expiry flag for the sequencer.
    always_comb expire = run && tick && (cnt <= 1);

    // R9: the count is frozen while the counter is idle and not loaded
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));
    // R2: a loaded interval is what the counter holds next
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/wd_pulse_gen.sv
// Stretches a single-cycle start request into an active-low pulse of LEN cycles.
// Assumes LEN >= 1. A restart during a pulse extends it to a full LEN again.
module wd_pulse_gen #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_n
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);

    logic [CW-1:0] cnt;

    // Remaining-cycles counter for the low pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= LEN_V;
        else if (cnt != 0)
            cnt <= cnt - 1'b1;
    end

    // Output low while cycles remain.
    always_comb pulse_n = (cnt == 0);

    // R5: a start request drives the pulse low on the next cycle
    p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !pulse_n);
    // R5: the counter never exceeds the pulse length
    p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LEN_V);
endmodule

// File: rtl/wd_recovery_fsm.sv
// Two-stage recovery sequencer. It holds the stage, the bus selection registers,
// and the reload and pulse requests. The enable bit is the first stage itself.
// Assumes expire comes from the tick counter in the same cycle.
module wd_recovery_fsm
    import wdfb_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic              sel_wr,
    input  logic              sel_src,
    input  logic [CODE_W-1:0] sel_code,
    input  logic [CODE_W-1:0] fb_code,
    input  logic              service,
    input  logic              expire,
    output wd_stage_e         stage,
    output logic              bus_src_q,
    output logic [CODE_W-1:0] bus_code_q,
    output logic              ctr_load,
    output logic              pulse_start
);
    logic arm, disarm, kick, fail, copy;

    // Event decode with priority disarm > service > expiry.
    always_comb begin
        arm         = (stage == WD_IDLE) && cfg_wr && cfg_en;
        disarm      = (stage == WD_TARGET) && cfg_wr && !cfg_en;
        kick        = service && (stage != WD_IDLE);
        fail        = expire && !kick && !disarm;
        copy        = service && (stage == WD_FALLBACK);
        ctr_load    = arm || kick || (fail && stage == WD_TARGET);
        pulse_start = fail;
    end

    // Stage register: idle -> target -> fall-back -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= WD_IDLE;
        else begin
            case (stage)
                WD_IDLE:     if (arm) stage <= WD_TARGET;
                WD_TARGET:   if (disarm) stage <= WD_IDLE;
                             else if (fail) stage <= WD_FALLBACK;
                WD_FALLBACK: if (copy || fail) stage <= WD_IDLE;
                default:     stage <= WD_IDLE;
            endcase
        end
    end

    // Bus selection registers: software writes, copy on success, strap on second failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_src_q  <= 1'b0;
            bus_code_q <= '0;
        end else if (copy) begin
            bus_src_q  <= 1'b1;
            bus_code_q <= fb_code;
        end else if (fail && stage == WD_FALLBACK) begin
            bus_src_q  <= 1'b0;
        end else if (sel_wr && stage != WD_FALLBACK) begin
            bus_src_q  <= sel_src;
            bus_code_q <= sel_code;
        end
    end

    // R4: an unserviced expiry in the first stage enters recovery
    p_first_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == WD_TARGET && expire && !service && !cfg_wr) |=> stage == WD_FALLBACK);
    // R6: an unserviced expiry in recovery reverts to the strap source
    p_second_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == WD_FALLBACK && expire && !service) |=> (stage == WD_IDLE && !bus_src_q));
    // R7: service in recovery adopts the fall-back code
    p_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == WD_FALLBACK && service) |=>
        (stage == WD_IDLE && bus_src_q && bus_code_q == $past(fb_code)));
    // R8: the bus code is untouched during recovery unless it is serviced
    p_fb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == WD_FALLBACK && !service) |=> $stable(bus_code_q));
endmodule

// File: rtl/freq_fallback_wdog.sv
// Top of the frequency fall-back watchdog. It ties the tick counter, the recovery
// sequencer and the reset pulse generator together and muxes the active frequency code.
// Assumes tick_1s is synchronous to clk and one cycle wide.
module freq_fallback_wdog
    import wdfb_pkg::*;
#(
    parameter int IVL_W     = 6,
    parameter int CODE_W    = 5,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [IVL_W-1:0]  cfg_interval,
    input  logic              sel_wr,
    input  logic              sel_src,
    input  logic [CODE_W-1:0] sel_code,
    input  logic [CODE_W-1:0] fb_code,
    input  logic [CODE_W-1:0] strap_code,
    input  logic              service,
    output logic              wd_rst_n,
    output logic [CODE_W-1:0] freq_code,
    output logic              wd_en,
    output logic              bus_src,
    output logic [CODE_W-1:0] bus_code
);
    wd_stage_e stage;
    logic      expire, ctr_load, pulse_start, running;

    // Counter runs in either watched stage.
    always_comb running = (stage != WD_IDLE);

    wd_tick_counter #(.IVL_W(IVL_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(cfg_interval),
        .run(running), .tick(tick_1s), .expire(expire)
    );

    wd_recovery_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .sel_wr(sel_wr), .sel_src(sel_src), .sel_code(sel_code), .fb_code(fb_code),
        .service(service), .expire(expire), .stage(stage),
        .bus_src_q(bus_src), .bus_code_q(bus_code),
        .ctr_load(ctr_load), .pulse_start(pulse_start)
    );

    wd_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(pulse_start), .pulse_n(wd_rst_n)
    );

    // Active frequency selection and enable readback.
    always_comb begin
        wd_en = (stage == WD_TARGET);
        if (stage == WD_FALLBACK)
            freq_code = fb_code;
        else if (bus_src)
            freq_code = bus_code;
        else
            freq_code = strap_code;
    end

    // R10: outside recovery with the strap source, the strap code is output
    p_src_mux_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != WD_FALLBACK && !bus_src) |-> freq_code == strap_code);
    // R5: the reset output only falls after an expiry in a watched stage
    p_reset_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |-> $past(stage) != WD_IDLE);
    // R9: an idle watchdog never reports expiry
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == WD_IDLE) |-> !expire);
endmodule

// File: tb/tb_freq_fallback_wdog.sv
`timescale 1ns/1ps
module tb_freq_fallback_wdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0, cfg_wr = 1'b0, cfg_en = 1'b0, sel_wr = 1'b0;
    logic       sel_src = 1'b0, service = 1'b0;
    logic [5:0] cfg_interval = '0;
    logic [4:0] sel_code = '0, fb_code = '0, strap_code = 5'h0A;
    logic       wd_rst_n, wd_en, bus_src;
    logic [4:0] freq_code, bus_code;

    freq_fallback_wdog dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_interval(cfg_interval), .sel_wr(sel_wr), .sel_src(sel_src),
        .sel_code(sel_code), .fb_code(fb_code), .strap_code(strap_code),
        .service(service), .wd_rst_n(wd_rst_n), .freq_code(freq_code),
        .wd_en(wd_en), .bus_src(bus_src), .bus_code(bus_code)
    );

    always #2 clk = ~clk;

    typedef struct {
        int         due;
        string      tag;
        logic [4:0] code;
        logic       rst;
        logic       en;
        logic       src;
        logic [4:0] bcode;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Expected state, maintained from the requirements.
    logic [4:0] e_code = 5'h0A, e_bcode = '0;
    logic       e_rst = 1'b1, e_en = 1'b0, e_src = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare every item due by this falling edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (freq_code !== e.code || wd_rst_n !== e.rst || wd_en !== e.en ||
                bus_src !== e.src || bus_code !== e.bcode) begin
                n_fail++;
                $display("FAIL %s: got code=%h rst=%b en=%b src=%b bcode=%h, expected code=%h rst=%b en=%b src=%b bcode=%h",
                    e.tag, freq_code, wd_rst_n, wd_en, bus_src, bus_code,
                    e.code, e.rst, e.en, e.src, e.bcode);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag);
        exp_t e;
        e.due = cyc; e.tag = tag; e.code = e_code; e.rst = e_rst;
        e.en = e_en; e.src = e_src; e.bcode = e_bcode;
        q.push_back(e);
    endtask

    task automatic do_tick();
        tick_1s = 1'b1; step(); tick_1s = 1'b0;
    endtask

    task automatic do_service();
        service = 1'b1; step(); service = 1'b0;
    endtask

    task automatic do_cfg(input logic en);
        cfg_wr = 1'b1; cfg_en = en; step(); cfg_wr = 1'b0;
    endtask

    task automatic do_sel(input logic [4:0] code, input logic src);
        sel_wr = 1'b1; sel_code = code; sel_src = src; step(); sel_wr = 1'b0;
    endtask

    // Reset pulse: low for the expiry cycle plus 15 more, high on the 16th after.
    task automatic check_pulse(input string tag);
        for (int k = 1; k <= 15; k++) begin
            step(); chk(tag);
        end
        step(); e_rst = 1'b1; chk(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1; step();
        chk("R1 reset state");

        // R10 source selection
        do_sel(5'h1C, 1'b1); e_code = 5'h1C; e_src = 1; e_bcode = 5'h1C; chk("R10 bus source");
        strap_code = 5'h0B; chk("R10 strap hidden by bus source");
        do_sel(5'h1C, 1'b0); e_code = 5'h0B; e_src = 0; chk("R10 strap source");
        do_sel(5'h1C, 1'b1); e_code = 5'h1C; e_src = 1; chk("R10 back to bus");

        // R9 idle: ticks and service do nothing
        for (int i = 0; i < 3; i++) begin do_tick(); chk("R9 idle tick"); end
        do_service(); chk("R9 idle service");

        // R2/R4/R5 first expiry after 3 ticks
        cfg_interval = 6'd3; fb_code = 5'h13;
        do_cfg(1'b1); e_en = 1; chk("R2 armed");
        do_tick(); chk("R2 tick1");
        do_tick(); chk("R2 tick2");
        do_tick(); e_en = 0; e_code = 5'h13; e_rst = 0; chk("R4 first expiry");
        // R8 writes ignored during recovery
        do_cfg(1'b1); chk("R8 enable write ignored");
        do_sel(5'h05, 1'b0); chk("R8 select write ignored");
        e_rst = 0;
        for (int k = 3; k <= 15; k++) begin step(); chk("R5 pulse low"); end
        step(); e_rst = 1; chk("R5 pulse ended");

        // R7 service in recovery
        do_service(); e_bcode = 5'h13; e_src = 1; e_code = 5'h13; chk("R7 success copy");
        do_tick(); chk("R9 idle after success");
        do_tick(); chk("R9 idle after success");

        // R3 kick, then R6 second failure
        cfg_interval = 6'd2; fb_code = 5'h07;
        do_cfg(1'b1); e_en = 1; chk("R2 armed 2");
        do_tick(); chk("R3 before kick");
        do_service(); chk("R3 kick");
        do_tick(); chk("R3 reload held");
        do_tick(); e_en = 0; e_code = 5'h07; e_rst = 0; chk("R3 expiry after reload");
        check_pulse("R5 pulse");
        do_tick(); chk("R6 recovery tick1");
        do_tick(); e_code = 5'h0B; e_src = 0; e_rst = 0; chk("R6 second expiry to strap");
        check_pulse("R5 second pulse");
        do_tick(); chk("R9 idle after revert");

        // R9 disarm
        cfg_interval = 6'd1;
        do_cfg(1'b1); e_en = 1; chk("R2 armed 3");
        do_cfg(1'b0); e_en = 0; chk("R9 disarmed");
        do_tick(); chk("R9 tick after disarm");
        do_tick(); chk("R9 tick after disarm");

        // R2 zero interval expires on first tick
        do_sel(5'h1C, 1'b1); e_code = 5'h1C; e_src = 1; e_bcode = 5'h1C; chk("R10 bus source again");
        cfg_interval = 6'd0;
        do_cfg(1'b1); e_en = 1; chk("R2 armed zero");
        do_tick(); e_en = 0; e_code = 5'h07; e_rst = 0; chk("R2 zero interval expiry");
        do_service(); e_bcode = 5'h07; e_src = 1; chk("R7 success zero");

        repeat (20) step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule